// File: doc/BRIEF.md
# Up-Counting Timer with One Compare Channel

This block is a small timer peripheral on a plain 32-bit read/write register bus. A counter of build-time width (16 or 32 bits) runs from zero up to a programmable wrap value and then returns to zero. Each wrap raises an overflow flag. A power-of-two prescaler sets the rate at which the counter steps. Software can read the counter width back from a read-only register, so one driver can serve both builds.

One compare channel watches the counter. When the channel is set to software-compare mode and the counter equals the channel's compare value on a counting tick, the channel flag sets. The flag can be seen in the channel control register and also in a shared status register. Writing one to the flag bit in either place clears it. When the channel interrupt enable is set, the interrupt output follows the flag.

Top module: `tick_timer`

Register offsets (byte address on `bus_addr`): 0x04 width info, 0x10 timer control, 0x14 count, 0x18 wrap value, 0x1C status, 0x20 channel control, 0x24 channel compare value.

## Requirements
- R1: A read at 0x04 returns the counter width in bits, in bits [23:16]. The value is 0x10 for a 16-bit build and 0x20 for a 32-bit build. All other bits read zero.
- R2: After reset, timer control, count, status, channel control and compare value all read zero, and the wrap value reads all ones for the configured width. Addresses with no register, and register bits with no meaning, read zero.
- R3: Timer control bit 3 set to 1 makes the counter step on every prescaled tick. While that bit is 0 the count holds its value.
- R4: Timer control bits [2:0] hold n, and the counter steps once every 2^n bus clocks. Starting from a stopped timer, the first step comes 2^n clocks after the enabling write.
- R5: On a tick where the count equals the wrap value, the count returns to 0 and timer control bit 7, the overflow flag, sets.
- R6: Writing 1 to timer control bit 7 clears the overflow flag. If a wrap occurs in the same cycle as that write, the flag stays set.
- R7: Any write to the count register sets the count to 0. This write takes priority over a tick in the same cycle.
- R8: Channel control bits [5:2] are the channel mode. When the mode is 0x4 (software compare) and a tick occurs while the count equals the compare value, channel control bit 7, the channel flag, sets. Any other mode, including 0 (off), never sets the flag.
- R9: Status bit 0 reads the channel flag. Writing 1 to status bit 0, or to channel control bit 7, clears the flag. If a compare match occurs in the same cycle as the clear, the flag stays set.
- R10: Channel control bit 6 is the interrupt enable. `irq` is high exactly when the channel flag and the interrupt enable are both 1.
- R11: The count, wrap value and compare value keep only the low counter-width bits of a write. Their upper bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register being accessed |
| bus_we | input | 1 | Write strobe; the write takes effect on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Channel interrupt request |

## Verification
The bench places a clear-flag write on the same edge as a compare match. A design where the clear wins would drop an event that the software has not yet seen. The bench also writes the count while the timer runs, and checks that the count is exactly zero rather than one, which catches a design that lets the tick win. Prescaler timing is checked one clock before and one clock after each expected step, so an off-by-one divider shows up. The channel is also run with its mode off and with its interrupt disabled, to show that the flag stays clear in the first case and `irq` stays low in the second.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 8;
    localparam int DIV_W  = 3;
    localparam int PRE_W  = (1 << DIV_W) - 1;

    localparam logic [ADDR_W-1:0] OFS_INFO   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_WRAP   = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_CH_CTL = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_CH_VAL = 8'h24;

    localparam logic [3:0] CH_MODE_SWCMP = 4'h4;

    typedef enum logic {
        CLK_HOLD = 1'b0,
        CLK_STEP = 1'b1
    } clk_mode_e;

    typedef struct packed {
        clk_mode_e        mode;
        logic [DIV_W-1:0] div;
    } tmr_ctrl_t;

    typedef struct packed {
        logic       ie;
        logic [3:0] mode;
    } ch_ctrl_t;

    function automatic logic [PRE_W-1:0] div_mask(input logic [DIV_W-1:0] n);
        logic [PRE_W:0] one_hot;
        one_hot = (PRE_W+1)'(1) << n;
        return PRE_W'(one_hot - 1'b1);
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tick_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    assign mask = div_mask(div);
    assign tick = run && ((pre_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // R4
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && div != '0) |=> (!tick || !$stable(div)));

endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          clr,
    input  logic [CW-1:0] wrap,
    input  logic          ovf_clr,
    output logic [CW-1:0] cnt,
    output logic          ovf
);

    logic [CW-1:0] cnt_q;
    logic          ovf_q;
    logic          wrap_ev;

    assign wrap_ev = tick && (cnt_q == wrap);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= wrap_ev ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
        end else if (wrap_ev) begin
            ovf_q <= 1'b1;
        end else if (ovf_clr) begin
            ovf_q <= 1'b0;
        end
    end

    assign cnt = cnt_q;
    assign ovf = ovf_q;

    // R5 R6
    wrap_sets_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_ev |=> (ovf_q && cnt_q == '0));

    // R7
    count_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0));

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tick_timer_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cmp,
    input  logic [3:0]    mode,
    input  logic          flag_clr,
    output logic          flag
);

    logic hit;
    logic flag_q;

    assign hit = tick && (mode == CH_MODE_SWCMP) && (cnt == cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;

    // R9
    match_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag_q);

    // R8
    flag_needs_match_chk: assert property (@(posedge clk) disable iff (rst)
        (!flag_q && mode != CH_MODE_SWCMP) |=> !flag_q);

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);

    localparam logic [7:0] WIDTH_CODE = 8'(CW);

    tmr_ctrl_t     ctrl_q;
    ch_ctrl_t      chc_q;
    logic [CW-1:0] wrap_q;
    logic [CW-1:0] cmp_q;

    logic wr_ctrl, wr_count, wr_wrap, wr_stat, wr_chc, wr_cmp;
    logic tick, ovf, flag, flag_clr;
    logic [CW-1:0] cnt;
    logic unused_wbits;

    assign unused_wbits = ^bus_wdata;

    assign wr_ctrl  = bus_we && (bus_addr == OFS_CTRL);
    assign wr_count = bus_we && (bus_addr == OFS_COUNT);
    assign wr_wrap  = bus_we && (bus_addr == OFS_WRAP);
    assign wr_stat  = bus_we && (bus_addr == OFS_STAT);
    assign wr_chc   = bus_we && (bus_addr == OFS_CH_CTL);
    assign wr_cmp   = bus_we && (bus_addr == OFS_CH_VAL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{mode: CLK_HOLD, div: '0};
            chc_q  <= '0;
            wrap_q <= '1;
            cmp_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.mode <= bus_wdata[3] ? CLK_STEP : CLK_HOLD;
                ctrl_q.div  <= bus_wdata[DIV_W-1:0];
            end
            if (wr_chc) begin
                chc_q.ie   <= bus_wdata[6];
                chc_q.mode <= bus_wdata[5:2];
            end
            if (wr_wrap) wrap_q <= CW'(bus_wdata);
            if (wr_cmp)  cmp_q  <= CW'(bus_wdata);
        end
    end

    assign flag_clr = (wr_chc && bus_wdata[7]) || (wr_stat && bus_wdata[0]);

    tmr_prescale u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl_q.mode == CLK_STEP),
        .div  (ctrl_q.div),
        .tick (tick)
    );

    tmr_count #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .clr     (wr_count),
        .wrap    (wrap_q),
        .ovf_clr (wr_ctrl && bus_wdata[7]),
        .cnt     (cnt),
        .ovf     (ovf)
    );

    tmr_chan #(.CW(CW)) u_ch0 (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .cnt      (cnt),
        .cmp      (cmp_q),
        .mode     (chc_q.mode),
        .flag_clr (flag_clr),
        .flag     (flag)
    );

    assign irq = flag && chc_q.ie;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_INFO:   bus_rdata[23:16] = WIDTH_CODE;
            OFS_CTRL:   bus_rdata[7:0]   = {ovf, 3'b000, ctrl_q.mode == CLK_STEP, ctrl_q.div};
            OFS_COUNT:  bus_rdata        = BUS_W'(cnt);
            OFS_WRAP:   bus_rdata        = BUS_W'(wrap_q);
            OFS_STAT:   bus_rdata[0]     = flag;
            OFS_CH_CTL: bus_rdata[7:0]   = {flag, chc_q.ie, chc_q.mode, 2'b00};
            OFS_CH_VAL: bus_rdata        = BUS_W'(cmp_q);
            default:    bus_rdata        = '0;
        endcase
    end

    // R10
    irq_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_STAT && !bus_rdata[0]) |-> !irq);

endmodule

// File: tb/test_tick_timer.sv
module test_tick_timer;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tick_timer i_tick_timer (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // reset read table: {address, expected value}; R2 R1
    localparam logic [39:0] RST_TBL [10] = '{
        {8'h04, 32'h0010_0000},
        {8'h10, 32'h0000_0000},
        {8'h14, 32'h0000_0000},
        {8'h18, 32'h0000_FFFF},
        {8'h1C, 32'h0000_0000},
        {8'h20, 32'h0000_0000},
        {8'h24, 32'h0000_0000},
        {8'h00, 32'h0000_0000},
        {8'h08, 32'h0000_0000},
        {8'h28, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_addr  = 8'h00;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
        bus_addr = 8'h00;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000 && !done) begin
                checks++;
                errors++;
                $display("FAIL watchdog actual=%0d expected<=20000", cyc);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);

        for (int i = 0; i < 10; i++) begin
            rd_check($sformatf("R2 reset read %h", RST_TBL[i][39:32]),
                     RST_TBL[i][39:32], RST_TBL[i][31:0]);
        end
        check("R10 irq after reset", {31'b0, irq}, 32'h0);

        // R5 wrap at 5
        wr(8'h18, 32'd5);
        wr(8'h14, 32'h0);
        wr(8'h10, 32'h08);
        wait_cyc(3);
        rd_check("R3 counting", 8'h14, 32'd3);
        wait_cyc(3);
        rd_check("R5 wrap to zero", 8'h14, 32'd0);
        rd_check("R5 overflow flag", 8'h10, 32'h88);
        // R6 clear overflow and stop
        wr(8'h10, 32'h80);
        rd_check("R6 overflow cleared", 8'h10, 32'h00);
        wait_cyc(3);
        rd_check("R3 hold when stopped", 8'h14, 32'd1);

        // R4 divide by 4
        wr(8'h18, 32'hFFFF);
        wr(8'h14, 32'h0);
        wr(8'h10, 32'h0A);
        wait_cyc(7);
        rd_check("R4 div4 before step", 8'h14, 32'd1);
        wait_cyc(1);
        rd_check("R4 div4 step", 8'h14, 32'd2);
        wr(8'h10, 32'h00);
        wr(8'h14, 32'h0);
        wr(8'h10, 32'h0B);
        wait_cyc(15);
        rd_check("R4 div8 before step", 8'h14, 32'd1);
        wait_cyc(1);
        rd_check("R4 div8 step", 8'h14, 32'd2);
        wr(8'h10, 32'h00);

        // R7 count write while running
        wr(8'h10, 32'h08);
        wait_cyc(4);
        wr(8'h14, 32'h1234);
        rd_check("R7 write zeroes count", 8'h14, 32'd0);
        wait_cyc(2);
        rd_check("R7 count resumes", 8'h14, 32'd2);
        wr(8'h10, 32'h00);

        // R8 compare match, mode 4, ie set
        wr(8'h14, 32'h0);
        wr(8'h24, 32'd3);
        wr(8'h20, 32'h50);
        wr(8'h10, 32'h08);
        wait_cyc(3);
        rd_check("R8 no flag before match", 8'h20, 32'h50);
        check("R10 irq low before match", {31'b0, irq}, 32'h0);
        wait_cyc(1);
        rd_check("R8 flag on match", 8'h20, 32'hD0);
        rd_check("R9 status mirror", 8'h1C, 32'h1);
        check("R10 irq high", {31'b0, irq}, 32'h1);
        wr(8'h1C, 32'h1);
        rd_check("R9 status clear", 8'h20, 32'h50);
        check("R10 irq low after clear", {31'b0, irq}, 32'h0);
        wr(8'h10, 32'h00);

        // R8 mode off never flags
        wr(8'h20, 32'h40);
        wr(8'h14, 32'h0);
        wr(8'h10, 32'h08);
        wait_cyc(5);
        rd_check("R8 mode off no flag", 8'h20, 32'h40);
        rd_check("R8 mode off status", 8'h1C, 32'h0);
        wr(8'h10, 32'h00);

        // R10 ie off
        wr(8'h20, 32'h10);
        wr(8'h14, 32'h0);
        wr(8'h10, 32'h08);
        wait_cyc(5);
        rd_check("R8 flag without ie", 8'h20, 32'h90);
        check("R10 irq masked", {31'b0, irq}, 32'h0);
        wr(8'h20, 32'h90);
        rd_check("R9 clear via ctrl bit7", 8'h20, 32'h10);
        wr(8'h10, 32'h00);

        // R9 set wins over clear
        wr(8'h20, 32'h50);
        wr(8'h24, 32'd2);
        wr(8'h14, 32'h0);
        wr(8'h10, 32'h08);
        wait_cyc(2);
        wr(8'h1C, 32'h1);
        rd_check("R9 set wins", 8'h20, 32'hD0);
        wr(8'h10, 32'h00);
        wr(8'h1C, 32'h1);
        rd_check("R9 clear when idle", 8'h20, 32'h50);

        // R11 truncation
        wr(8'h18, 32'h0001_2345);
        rd_check("R11 wrap truncated", 8'h18, 32'h2345);
        wr(8'h24, 32'h00AB_CDEF);
        rd_check("R11 compare truncated", 8'h24, 32'hCDEF);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule